// File: doc/BRIEF.md
# Chained DMA Channel Controller

This block is one DMA channel. Software programs it through three 32-bit registers: a control/status word, a current address and a byte count. When enabled, the channel moves words between a peripheral and a simple request/acknowledge memory port. It works in bursts whose length comes from a two-bit code. A peripheral starts a burst by holding its request line high. Each accepted word advances the address by four and, when counting is enabled, takes four off the byte count.

The channel holds two buffer descriptors: the active address/count pair and one queued pair. When the active buffer reaches terminal count and chaining is enabled, the queued pair takes its place at once, so buffers follow one another with no software gap. Interrupts are raised by terminal count (unless that source is masked), by a request line from the peripheral, and by a memory error response. An error parks the engine until software issues a channel reset. A reset that arrives while a memory cycle is outstanding shows a drain state until that cycle completes.

Top module: `dma_chan_ctl`

## Requirements
- R1: Registers are word-aligned at byte offsets 0x0 (control/status), 0x4 (address) and 0x8 (count). A read returns data on `reg_rdata` one clock after `reg_re`. Address and count read back their live values, so the count read is the residue, zero-extended.
- R2: Control/status bits. Read/write bits: 4 interrupt enable, 8 direction (1 means memory write), 9 channel enable, 13 count enable, 19:18 burst code, 23 terminal-count interrupt mask, 24 chain enable. Write-one-to-clear bits: 0 interrupt pending, 1 error pending, 14 terminal count. Read-only bits: 2 draining, 10 memory cycle outstanding, 25 armed (enable AND current pair loaded AND not halted), 26 current pair loaded, 27 queued pair loaded, 31:28 the DEV_ID parameter. Bit 7 is the channel reset command. All other bits read 0.
- R3: Burst code 00 gives 4 words, 01 gives 8, 10 gives 1 and 11 gives 16. A burst ends early at terminal count. A new burst starts one idle cycle later if the peripheral request is still high.
- R4: The count register keeps only its low CW bits; higher written bits are dropped.
- R5: A write to the address register while enable is set loads the pair {address, last written count}. The pair goes into the current slot if that slot is empty, into the queued slot if only that one is empty, and is dropped if both are full. A queued pair is never overwritten. The write is ignored while enable is clear.
- R6: Each accepted word adds 4 to the address. With count enable set it also takes 4 from the count (saturating at 0). With count enable clear the count does not change.
- R7: A word accepted with count enable set and count ≤ 4 is terminal count: it ends the burst and sets bits 14 and 0. With chain enable and a queued pair present, that pair becomes current and the queued flag clears; otherwise the current flag clears.
- R8: With bit 23 set, terminal count still sets bit 14 but does not set bit 0.
- R9: A high `dev_irq` sets bit 0 without setting bit 14.
- R10: Writing back a value read from control/status clears exactly the pending bits that were set in it and leaves the control fields unchanged.
- R11: An error response ends the cycle, sets bit 1 and halts the engine. No further memory requests are made until a reset command, even after bit 1 is cleared.
- R12: A reset command clears all control fields, pending bits and both pairs. If a memory cycle is outstanding, `mem_req` stays high and bit 2 reads 1 until the response arrives, after which bits 2 and 10 read 0.
- R13: `irq` is registered: it equals interrupt enable AND (bit 0 OR bit 1), taken from the previous clock.
- R14: Once `mem_req` is high it stays high until `mem_ack` or `mem_err` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data |
| dev_req | input | 1 | Peripheral ready for a burst |
| dev_irq | input | 1 | Peripheral interrupt request |
| dev_wdata | input | DW | Peripheral data toward memory |
| dev_rdata | output | DW | Memory data toward peripheral |
| dev_beat | output | 1 | One pulse per accepted word |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory write when 1 |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_ack | input | 1 | Memory cycle completed |
| mem_err | input | 1 | Memory cycle failed |
| irq | output | 1 | Channel interrupt |

## Verification
The bench uses the default widths (32-bit address and data, 24-bit count) and sets DEV_ID to 0xA, so the ID field is checked as a non-zero value. The bench's memory responder has a latency that can be changed during the run. A short latency exercises back-to-back beats and chained promotion. A 40-cycle latency keeps a cycle outstanding long enough to read the drain state after a reset command. Buffers are kept to a few words, so every burst code, a mid-burst terminal count and a chain handover all occur within a few hundred cycles.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {RG_CSR = 2'd0, RG_ADDR = 2'd1, RG_CNT = 2'd2} dmac_reg_e;

  localparam int B_IP    = 0;
  localparam int B_EP    = 1;
  localparam int B_DRAIN = 2;
  localparam int B_IEN   = 4;
  localparam int B_RST   = 7;
  localparam int B_DIR   = 8;
  localparam int B_EN    = 9;
  localparam int B_CYC   = 10;
  localparam int B_CNTEN = 13;
  localparam int B_TC    = 14;
  localparam int B_BSZ   = 18;
  localparam int B_TCID  = 23;
  localparam int B_NEN   = 24;
  localparam int B_ON    = 25;
  localparam int B_CV    = 26;
  localparam int B_NV    = 27;
  localparam int STEP    = 4;
endpackage

// File: rtl/dmac_burst_dec.sv
module dmac_burst_dec #(
  parameter int BW = 5
) (
  input  logic [1:0]    code,
  output logic [BW-1:0] len
);
  always_comb begin
    case (code)
      2'b00:   len = BW'(4);
      2'b01:   len = BW'(8);
      2'b10:   len = BW'(1);
      default: len = BW'(16);
    endcase
  end
endmodule

// File: rtl/dmac_pair_q.sv
module dmac_pair_q #(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          beat,
  input  logic          cnt_en,
  input  logic          retire,
  input  logic          chain,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [CW-1:0] ld_cnt,
  output logic          cur_vld,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output logic          nxt_vld
);
  import dmac_pkg::*;

  logic [AW-1:0] nxt_addr, ca_n, na_n;
  logic [CW-1:0] nxt_cnt, cc_n, nc_n;
  logic          cv_n, nv_n;

  always_comb begin
    cv_n = cur_vld; ca_n = cur_addr; cc_n = cur_cnt;
    nv_n = nxt_vld; na_n = nxt_addr; nc_n = nxt_cnt;
    if (clr) begin
      cv_n = 1'b0; ca_n = '0; cc_n = '0;
      nv_n = 1'b0; na_n = '0; nc_n = '0;
    end else begin
      if (beat) begin
        ca_n = cur_addr + AW'(STEP);
        if (cnt_en) cc_n = (cur_cnt <= CW'(STEP)) ? '0 : cur_cnt - CW'(STEP);
      end
      if (retire) begin
        if (chain && nxt_vld) begin
          ca_n = nxt_addr; cc_n = nxt_cnt; nv_n = 1'b0;
        end else begin
          cv_n = 1'b0;
        end
      end
      if (load) begin
        if (!cv_n) begin
          cv_n = 1'b1; ca_n = ld_addr; cc_n = ld_cnt;
        end else if (!nv_n) begin
          nv_n = 1'b1; na_n = ld_addr; nc_n = ld_cnt;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_vld <= 1'b0; cur_addr <= '0; cur_cnt <= '0;
      nxt_vld <= 1'b0; nxt_addr <= '0; nxt_cnt <= '0;
    end else begin
      cur_vld <= cv_n; cur_addr <= ca_n; cur_cnt <= cc_n;
      nxt_vld <= nv_n; nxt_addr <= na_n; nxt_cnt <= nc_n;
    end
  end

  // R5: a queued pair survives any load attempt
  p_next_kept_r5: assert property (@(posedge clk) disable iff (rst)
    nxt_vld && !clr && !retire |=> nxt_vld && $stable(nxt_addr) && $stable(nxt_cnt));
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine #(
  parameter int CW = 24,
  parameter int BW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rcmd,
  input  logic          arm,
  input  logic          dev_req,
  input  logic [BW-1:0] burst_len,
  input  logic          cnt_en,
  input  logic [CW-1:0] cur_cnt,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic          mem_req,
  output logic          drain,
  output logic          halt,
  output logic          beat,
  output logic          tc_hit,
  output logic          err_hit
);
  import dmac_pkg::*;

  logic [BW-1:0] left;
  logic          resp, go;

  assign resp    = mem_req && (mem_ack || mem_err);
  assign beat    = mem_req && mem_ack && !mem_err && !drain && !rcmd;
  assign err_hit = mem_req && mem_err && !drain && !rcmd;
  assign tc_hit  = beat && cnt_en && (cur_cnt <= CW'(STEP));
  assign go      = !mem_req && arm && !halt && dev_req && !rcmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req <= 1'b0; drain <= 1'b0; halt <= 1'b0; left <= '0;
    end else if (rcmd) begin
      mem_req <= mem_req && !resp;
      drain   <= mem_req && !resp;
      halt    <= 1'b0;
    end else if (drain) begin
      if (resp) begin
        mem_req <= 1'b0; drain <= 1'b0;
      end
    end else if (mem_req) begin
      if (err_hit) begin
        mem_req <= 1'b0; halt <= 1'b1;
      end else if (beat) begin
        left <= left - BW'(1);
        if (left == BW'(1) || tc_hit) mem_req <= 1'b0;
      end
    end else if (go) begin
      mem_req <= 1'b1;
      left    <= burst_len;
    end
  end

  // R14: request held until a response
  p_req_hold_r14: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack && !mem_err |=> mem_req);
  // R12: drain only while a cycle is outstanding
  p_drain_req_r12: assert property (@(posedge clk) disable iff (rst)
    drain |-> mem_req);
  // R11: halted engine issues no new cycle
  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    halt && !mem_req |=> !mem_req);
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl #(
  parameter int          AW     = 32,
  parameter int          DW     = 32,
  parameter int          CW     = 24,
  parameter logic [3:0]  DEV_ID = 4'h3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          dev_req,
  input  logic          dev_irq,
  input  logic [DW-1:0] dev_wdata,
  output logic [DW-1:0] dev_rdata,
  output logic          dev_beat,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic          irq
);
  import dmac_pkg::*;
  localparam int BW = 5;

  logic          int_en, dir, en, cnt_en, tcid, nen;
  logic [1:0]    bsz;
  logic          ipend, epend, tc;
  logic [CW-1:0] cnt_stage;
  logic [DW-1:0] csr_val;
  logic          cur_vld, nxt_vld, drain, halt, beat, tc_hit, err_hit;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] cur_cnt;
  logic [BW-1:0] burst_len;
  logic          aligned, csr_wr, rcmd, addr_wr, cnt_wr, load;
  dmac_reg_e     idx;
  logic          unused_bits;

  assign unused_bits = ^reg_wdata;
  assign aligned = (reg_addr[1:0] == 2'b00);
  assign idx     = dmac_reg_e'(reg_addr[3:2]);
  assign csr_wr  = reg_we && aligned && idx == RG_CSR;
  assign addr_wr = reg_we && aligned && idx == RG_ADDR;
  assign cnt_wr  = reg_we && aligned && idx == RG_CNT;
  assign rcmd    = csr_wr && reg_wdata[B_RST];
  assign load    = addr_wr && en;

  dmac_burst_dec #(.BW(BW)) u_dec (.code(bsz), .len(burst_len));

  dmac_pair_q #(.AW(AW), .CW(CW)) u_pairs (
    .clk(clk), .rst(rst), .clr(rcmd), .beat(beat), .cnt_en(cnt_en),
    .retire(tc_hit), .chain(nen), .load(load), .ld_addr(reg_wdata[AW-1:0]),
    .ld_cnt(cnt_stage), .cur_vld(cur_vld), .cur_addr(cur_addr),
    .cur_cnt(cur_cnt), .nxt_vld(nxt_vld));

  dmac_engine #(.CW(CW), .BW(BW)) u_eng (
    .clk(clk), .rst(rst), .rcmd(rcmd), .arm(en && cur_vld), .dev_req(dev_req),
    .burst_len(burst_len), .cnt_en(cnt_en), .cur_cnt(cur_cnt),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_req(mem_req), .drain(drain),
    .halt(halt), .beat(beat), .tc_hit(tc_hit), .err_hit(err_hit));

  assign mem_addr  = cur_addr;
  assign mem_we    = dir;
  assign mem_wdata = dev_wdata;

  always_comb begin
    csr_val            = '0;
    csr_val[B_IP]      = ipend;
    csr_val[B_EP]      = epend;
    csr_val[B_DRAIN]   = drain;
    csr_val[B_IEN]     = int_en;
    csr_val[B_DIR]     = dir;
    csr_val[B_EN]      = en;
    csr_val[B_CYC]     = mem_req;
    csr_val[B_CNTEN]   = cnt_en;
    csr_val[B_TC]      = tc;
    csr_val[B_BSZ+:2]  = bsz;
    csr_val[B_TCID]    = tcid;
    csr_val[B_NEN]     = nen;
    csr_val[B_ON]      = en && cur_vld && !halt;
    csr_val[B_CV]      = cur_vld;
    csr_val[B_NV]      = nxt_vld;
    csr_val[DW-1:DW-4] = DEV_ID;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {int_en, dir, en, cnt_en, tcid, nen} <= '0;
      bsz <= '0; ipend <= 1'b0; epend <= 1'b0; tc <= 1'b0;
      cnt_stage <= '0; irq <= 1'b0; reg_rdata <= '0;
      dev_beat <= 1'b0; dev_rdata <= '0;
    end else begin
      irq      <= int_en && (ipend || epend);
      dev_beat <= beat;
      if (beat && !dir) dev_rdata <= mem_rdata;
      if (reg_re) begin
        if (!aligned)            reg_rdata <= '0;
        else if (idx == RG_CSR)  reg_rdata <= csr_val;
        else if (idx == RG_ADDR) reg_rdata <= DW'(cur_addr);
        else if (idx == RG_CNT)  reg_rdata <= DW'(cur_cnt);
        else                     reg_rdata <= '0;
      end
      if (rcmd) begin
        {int_en, dir, en, cnt_en, tcid, nen} <= '0;
        bsz <= '0; ipend <= 1'b0; epend <= 1'b0; tc <= 1'b0;
        cnt_stage <= '0;
      end else begin
        ipend <= (ipend && !(csr_wr && reg_wdata[B_IP])) || (tc_hit && !tcid) || dev_irq;
        epend <= (epend && !(csr_wr && reg_wdata[B_EP])) || err_hit;
        tc    <= (tc && !(csr_wr && reg_wdata[B_TC])) || tc_hit;
        if (csr_wr) begin
          int_en <= reg_wdata[B_IEN];
          dir    <= reg_wdata[B_DIR];
          en     <= reg_wdata[B_EN];
          cnt_en <= reg_wdata[B_CNTEN];
          bsz    <= reg_wdata[B_BSZ+:2];
          tcid   <= reg_wdata[B_TCID];
          nen    <= reg_wdata[B_NEN];
        end
        if (cnt_wr) cnt_stage <= reg_wdata[CW-1:0];
      end
    end
  end

  // R8: masked terminal count never raises the pending bit
  p_tcid_r8: assert property (@(posedge clk) disable iff (rst)
    tcid && !ipend && !dev_irq && !csr_wr |=> !ipend);
  // R13: interrupt line quiet while interrupts are disabled
  p_irq_off_r13: assert property (@(posedge clk) disable iff (rst)
    !int_en |=> !irq);
endmodule

// File: tb/sim_dma_chan_ctl.sv
module sim_dma_chan_ctl;
  localparam logic [3:0] DEV = 4'hA;

  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_we = 0, reg_re = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        dev_req = 0, dev_irq = 0;
  logic [31:0] dev_wdata = 32'h5A5A_0000, dev_rdata;
  logic        dev_beat, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 32'h1234_5678;
  logic        mem_ack = 0, mem_err = 0, irq;

  int nchk = 0, nerr = 0, cyc = 0, lat = 1, wcnt = 0, nburst = 0, nbeat = 0;
  bit err_arm = 0, prev_req = 0;

  always #2.5 clk = ~clk;

  dma_chan_ctl #(.DEV_ID(DEV)) u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_req(dev_req),
    .dev_irq(dev_irq), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
    .dev_beat(dev_beat), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_req, m_drn, m_halt, m_ien, m_dir, m_en, m_cnten, m_tcid, m_nen;
  bit m_ip, m_ep, m_tc, m_cv, m_nv, m_irq, m_dbeat;
  bit [1:0] m_bsz;
  int m_left;
  logic [31:0] m_ca, m_na, m_rd;
  int unsigned m_cc, m_nc, m_stage;

  function automatic int blen(input bit [1:0] c);
    case (c) 2'd0: return 4; 2'd1: return 8; 2'd2: return 1; default: return 16; endcase
  endfunction

  always @(posedge clk) begin : mdl
    bit rc, resp, bt, eh, tch, go, ld, cw;
    logic [31:0] cs;
    cyc++;
    if (rst) begin
      {m_req, m_drn, m_halt, m_ien, m_dir, m_en, m_cnten, m_tcid, m_nen} = '0;
      {m_ip, m_ep, m_tc, m_cv, m_nv, m_irq, m_dbeat} = '0;
      m_bsz = 0; m_left = 0; m_ca = 0; m_na = 0; m_rd = 0;
      m_cc = 0; m_nc = 0; m_stage = 0;
    end else begin
      cw   = reg_we && reg_addr == 4'h0;
      rc   = cw && reg_wdata[7];
      resp = m_req && (mem_ack || mem_err);
      bt   = m_req && mem_ack && !mem_err && !m_drn && !rc;
      eh   = m_req && mem_err && !m_drn && !rc;
      tch  = bt && m_cnten && (m_cc <= 4);
      go   = !m_req && m_en && m_cv && !m_halt && dev_req && !rc;
      ld   = reg_we && reg_addr == 4'h4 && m_en;
      cs = 0;
      cs[31:28] = DEV; cs[27] = m_nv; cs[26] = m_cv; cs[25] = m_en && m_cv && !m_halt;
      cs[24] = m_nen; cs[23] = m_tcid; cs[19:18] = m_bsz; cs[14] = m_tc;
      cs[13] = m_cnten; cs[10] = m_req; cs[9] = m_en; cs[8] = m_dir; cs[4] = m_ien;
      cs[2] = m_drn; cs[1] = m_ep; cs[0] = m_ip;
      if (reg_re) m_rd = (reg_addr == 0) ? cs : (reg_addr == 4) ? m_ca :
                         (reg_addr == 8) ? m_cc : 32'h0;
      m_irq = m_ien && (m_ip || m_ep);
      m_dbeat = bt;
      // descriptors
      if (rc) begin
        m_cv = 0; m_nv = 0; m_ca = 0; m_cc = 0; m_na = 0; m_nc = 0; m_stage = 0;
      end else begin
        if (bt) begin
          m_ca += 4;
          if (m_cnten) m_cc = (m_cc <= 4) ? 0 : m_cc - 4;
        end
        if (tch) begin
          if (m_nen && m_nv) begin m_ca = m_na; m_cc = m_nc; m_nv = 0; end
          else m_cv = 0;
        end
        if (ld) begin
          if (!m_cv) begin m_cv = 1; m_ca = reg_wdata; m_cc = m_stage; end
          else if (!m_nv) begin m_nv = 1; m_na = reg_wdata; m_nc = m_stage; end
        end
        if (reg_we && reg_addr == 4'h8) m_stage = reg_wdata & 32'h00FF_FFFF;
      end
      // status / control
      if (rc) begin
        {m_ien, m_dir, m_en, m_cnten, m_tcid, m_nen, m_ip, m_ep, m_tc} = '0;
        m_bsz = 0;
      end else begin
        m_ip = (m_ip && !(cw && reg_wdata[0])) || (tch && !m_tcid) || dev_irq;
        m_ep = (m_ep && !(cw && reg_wdata[1])) || eh;
        m_tc = (m_tc && !(cw && reg_wdata[14])) || tch;
        if (cw) begin
          m_ien = reg_wdata[4]; m_dir = reg_wdata[8]; m_en = reg_wdata[9];
          m_cnten = reg_wdata[13]; m_bsz = reg_wdata[19:18];
          m_tcid = reg_wdata[23]; m_nen = reg_wdata[24];
        end
      end
      // engine
      if (rc) begin
        m_drn = m_req && !resp; m_req = m_req && !resp; m_halt = 0;
      end else if (m_drn) begin
        if (resp) begin m_req = 0; m_drn = 0; end
      end else if (m_req) begin
        if (eh) begin m_req = 0; m_halt = 1; end
        else if (bt) begin
          if (m_left == 1 || tch) m_req = 0;
          m_left--;
        end
      end else if (go) begin
        m_req = 1; m_left = blen(m_bsz);
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R14 mem_req", mem_req, m_req);
      if (m_req) chk("R6 mem_addr", mem_addr, m_ca);
      chk("R13 irq", irq, m_irq);
      chk("R1 reg_rdata", reg_rdata, m_rd);
      chk("R3 dev_beat", dev_beat, m_dbeat);
      if (mem_req && !prev_req) nburst++;
      if (dev_beat) nbeat++;
    end
    prev_req = mem_req;
  end

  // memory responder
  always @(negedge clk) begin
    if (mem_ack || mem_err) begin mem_ack = 0; mem_err = 0; wcnt = 0; end
    else if (mem_req) begin
      if (wcnt >= lat) begin if (err_arm) mem_err = 1; else mem_ack = 1; end
      else wcnt++;
    end else wcnt = 0;
  end

  always @(posedge clk) if (cyc > 100000) begin
    nerr++; nchk++;
    $display("FAIL watchdog actual=%0d expected<100000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); reg_re = 1; reg_addr = a;
    @(negedge clk); reg_re = 0; v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    idle(3); rst = 0; idle(1);
    rd(4'h0, v); chk("R2 reset csr", v, 32'hA000_0000);
    rd(4'h8, v); chk("R1 reset count", v, 0);
    // chained run, 4-word bursts
    wr(4'h0, 32'h0100_2210);
    rd(4'h0, v); chk("R2 control readback", v, 32'hA100_2210);
    wr(4'h8, 40);  wr(4'h4, 32'h1000);
    wr(4'h8, 8);   wr(4'h4, 32'h2000);
    wr(4'h8, 12);  wr(4'h4, 32'h3000);
    rd(4'h8, v); chk("R1 count residue", v, 40);
    rd(4'h0, v); chk("R5 both slots loaded", v, 32'hAF00_2210);
    nburst = 0; nbeat = 0; lat = 1; dev_req = 1;
    idle(150);
    chk("R3 four bursts", nburst, 4);
    chk("R6 twelve words", nbeat, 12);
    rd(4'h4, v); chk("R7 chained buffer end addr", v, 32'h2008);
    rd(4'h8, v); chk("R6 count at zero", v, 0);
    rd(4'h0, v); chk("R7 tc and pending", v, 32'hA100_6211);
    chk("R13 irq high", irq, 1);
    wr(4'h0, v);
    rd(4'h0, v); chk("R10 write-back clears", v, 32'hA100_2210);
    idle(2); chk("R13 irq low", irq, 0);
    // single-word bursts, masked terminal count
    nburst = 0;
    wr(4'h0, 32'h0088_2200); wr(4'h8, 8); wr(4'h4, 32'h4000);
    idle(50);
    chk("R3 one-word bursts", nburst, 2);
    rd(4'h0, v); chk("R8 tc without pending", v, 32'hA088_6200);
    rd(4'h4, v); chk("R6 address step", v, 32'h4008);
    wr(4'h0, 32'h0088_6200);
    rd(4'h0, v); chk("R10 tc cleared", v, 32'hA088_2200);
    @(negedge clk); dev_irq = 1; @(negedge clk); dev_irq = 0;
    rd(4'h0, v); chk("R9 device request", v, 32'hA088_2201);
    wr(4'h0, 32'h0088_2201);
    // counting disabled, 16-word code, reset while a cycle is outstanding
    dev_req = 0;
    wr(4'h0, 32'h000C_0300); wr(4'h8, 32'hFF00_0008); wr(4'h4, 32'h5000);
    rd(4'h8, v); chk("R4 count truncated", v, 8);
    lat = 2; dev_req = 1; idle(30);
    rd(4'h8, v); chk("R6 count held", v, 8);
    lat = 40;
    while (mem_ack || !mem_req) @(negedge clk);
    idle(1);
    wr(4'h0, 32'h0000_0080);
    rd(4'h0, v); chk("R12 draining", v, 32'hA000_0404);
    idle(60);
    rd(4'h0, v); chk("R12 drained", v, 32'hA000_0000);
    chk("R12 request dropped", mem_req, 0);
    // error response
    dev_req = 0; lat = 2; err_arm = 1;
    wr(4'h0, 32'h0000_2210); wr(4'h8, 16); wr(4'h4, 32'h6000);
    dev_req = 1; idle(20);
    rd(4'h0, v); chk("R11 error halts", v, 32'hA400_2212);
    chk("R13 irq on error", irq, 1);
    err_arm = 0;
    wr(4'h0, 32'h0000_2212); idle(20);
    chk("R11 still halted", mem_req, 0);
    rd(4'h4, v); chk("R11 address unchanged", v, 32'h6000);
    wr(4'h0, 32'h0000_0080);
    rd(4'h0, v); chk("R12 reset clears", v, 32'hA000_0000);
    dev_req = 0; idle(4);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule